// File: doc/BRIEF.md
# Clock Gate with Shared Ownership and Turn-Off Hysteresis

This block decides whether a downstream clock runs. Ownership of that decision goes to one of two sources. When the owner-select bit is 1, a software enable bit drives the gate. When it is 0, a hardware request input drives it and the software enable bit has no effect. A keep-on bit forces the gate to stay running while software owns it, whatever the enable bit holds. This suits clocks that must never stop.

Turning the gate on takes one clock cycle. Turning it off can be delayed by a programmable hysteresis. With hysteresis off, the gate closes one cycle after the request drops. With hysteresis on, a level bit selects a short or a long extra delay, both set in cycles by parameters. If the request comes back before the delay runs out, the pending turn-off is cancelled. A status output repeats the gate state a fixed settling time after the gate output has actually changed, so software can poll it to learn that a change has completed.

Top module: `clk_gate_hyst`

## Requirements
- R1: During and right after reset, `gate_en` and `gate_status` are both 0.
- R2: With `sw_select`=1, `sw_enable`=1 opens the gate and `sw_enable`=0 closes it. `hw_req` has no effect in this mode.
- R3: With `sw_select`=0, `hw_req` alone opens and closes the gate. `sw_enable` is ignored.
- R4: `gate_status` equals the value `gate_en` held SETTLE cycles earlier. It never changes before `gate_en` has changed.
- R5: With `sw_select`=1 and `keep_on`=1, the gate opens and stays open even when `sw_enable` is 0.
- R6: With `hyst_en`=0, `gate_en` falls at the first clock edge that sees the request low, which is one cycle after the drop.
- R7: With `hyst_en`=1 and `hyst_long`=0, `gate_en` falls SHORT_OFF cycles later than under R6.
- R8: With `hyst_en`=1 and `hyst_long`=1, `gate_en` falls LONG_OFF cycles later than under R6.
- R9: If the request returns while a turn-off delay is counting, the gate stays open and the pending turn-off is dropped.
- R10: A closed gate opens one cycle after the request rises. Hysteresis settings do not change this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 1 | Hardware request for the clock |
| sw_select | input | 1 | Owner select: 1 = software owns the gate, 0 = hardware owns it |
| sw_enable | input | 1 | Software enable, used only when software owns the gate |
| keep_on | input | 1 | Forces the gate on while software owns it |
| hyst_en | input | 1 | Enables the turn-off delay |
| hyst_long | input | 1 | Turn-off delay length: 0 = short, 1 = long |
| gate_en | output | 1 | Enable for the gated clock |
| gate_status | output | 1 | Gate state after the settling latency |

## Verification
The assertions check on every cycle that a request reaching a closed gate opens it at the next edge. They also check that the gate falls only at an edge where the request was low, that a keep-on gate under software ownership never closes, and that a closed gate stays closed under hardware ownership with no request. The turn-off delay counter is checked to stay within the long delay. The exact short and long turn-off delays, the cancellation of a pending turn-off, and the status lag of SETTLE cycles are shown only by the bench's scenarios, which count edges from each stimulus.

// File: rtl/clk_gate_hyst_pkg.sv
package clk_gate_hyst_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_DRAIN = 2'd2
    } gate_st_e;
endpackage

// File: rtl/gate_req_sel.sv
module gate_req_sel (
    input  logic hw_req,
    input  logic sw_select,
    input  logic sw_enable,
    input  logic keep_on,
    output logic want
);
    always_comb begin
        if (sw_select) begin
            want = sw_enable | keep_on;
        end else begin
            want = hw_req;
        end
    end
endmodule

// File: rtl/gate_off_timer.sv
module gate_off_timer
    import clk_gate_hyst_pkg::*;
#(
    parameter int SHORT_OFF = 4,
    parameter int LONG_OFF  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic hyst_en,
    input  logic hyst_long,
    output logic gate_on
);
    localparam int CW = $clog2(LONG_OFF + 1);
    localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_OFF - 1);
    localparam logic [CW-1:0] LONG_LD  = CW'(LONG_OFF - 1);

    typedef struct packed {
        gate_st_e      st;
        logic [CW-1:0] cnt;
        logic          gate;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ST_OFF: begin
                if (want) begin
                    nxt_d.st   = ST_ON;
                    nxt_d.gate = 1'b1;
                end
            end
            ST_ON: begin
                if (!want) begin
                    if (hyst_en) begin
                        nxt_d.st  = ST_DRAIN;
                        nxt_d.cnt = hyst_long ? LONG_LD : SHORT_LD;
                    end else begin
                        nxt_d.st   = ST_OFF;
                        nxt_d.gate = 1'b0;
                    end
                end
            end
            ST_DRAIN: begin
                if (want) begin
                    nxt_d.st = ST_ON;
                end else if (cur_q.cnt == '0) begin
                    nxt_d.st   = ST_OFF;
                    nxt_d.gate = 1'b0;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            default: begin
                nxt_d.st   = ST_OFF;
                nxt_d.gate = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_OFF, cnt: '0, gate: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign gate_on = cur_q.gate;

    AST_PROMPT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (want && !gate_on) |=> gate_on);  // R10
    AST_FALL_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_on) |-> !$past(want));  // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= LONG_LD);  // R8
endmodule

// File: rtl/gate_status_pipe.sv
module gate_status_pipe #(
    parameter int SETTLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    output logic status
);
    logic [SETTLE-1:0] pipe_d, pipe_q;

    generate
        if (SETTLE > 1) begin : g_deep
            always_comb pipe_d = {pipe_q[SETTLE-2:0], gate_on};
        end else begin : g_single
            always_comb pipe_d = gate_on;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign status = pipe_q[SETTLE-1];
endmodule

// File: rtl/clk_gate_hyst.sv
module clk_gate_hyst #(
    parameter int SETTLE    = 3,
    parameter int SHORT_OFF = 4,
    parameter int LONG_OFF  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_req,
    input  logic sw_select,
    input  logic sw_enable,
    input  logic keep_on,
    input  logic hyst_en,
    input  logic hyst_long,
    output logic gate_en,
    output logic gate_status
);
    logic want;

    gate_req_sel u_sel (
        .hw_req    (hw_req),
        .sw_select (sw_select),
        .sw_enable (sw_enable),
        .keep_on   (keep_on),
        .want      (want)
    );

    gate_off_timer #(
        .SHORT_OFF (SHORT_OFF),
        .LONG_OFF  (LONG_OFF)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .hyst_en   (hyst_en),
        .hyst_long (hyst_long),
        .gate_on   (gate_en)
    );

    gate_status_pipe #(
        .SETTLE (SETTLE)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_on (gate_en),
        .status  (gate_status)
    );

    AST_KEEP_ON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_select && keep_on && gate_en) |=> gate_en);  // R5
    AST_HW_IDLE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_select && !hw_req && !gate_en) |=> !gate_en);  // R3
endmodule

// File: tb/clk_gate_hyst_tb.sv
`timescale 1ns/1ps
module clk_gate_hyst_tb;
    localparam int SETTLE    = 3;
    localparam int SHORT_OFF = 4;
    localparam int LONG_OFF  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_req = 1'b0, sw_select = 1'b0, sw_enable = 1'b0, keep_on = 1'b0;
    logic hyst_en = 1'b0, hyst_long = 1'b0;
    logic gate_en, gate_status;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    clk_gate_hyst #(.SETTLE(SETTLE), .SHORT_OFF(SHORT_OFF), .LONG_OFF(LONG_OFF)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_select(sw_select),
        .sw_enable(sw_enable), .keep_on(keep_on), .hyst_en(hyst_en),
        .hyst_long(hyst_long), .gate_en(gate_en), .gate_status(gate_status)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_off();
        sw_select = 1'b1; sw_enable = 1'b0; keep_on = 1'b0; hw_req = 1'b0;
        hyst_en = 1'b0; hyst_long = 1'b0;
        tick(LONG_OFF + SETTLE + 3);
    endtask

    task automatic count_to_off(output int n);
        n = 0;
        while (gate_en && n < 100) begin
            tick(1);
            n++;
        end
    endtask

    task automatic t_reset();
        check("R1", "gate during reset", int'(gate_en), 0);
        check("R1", "status during reset", int'(gate_status), 0);
        tick(1);
        rst_n = 1'b1;
        tick(2);
        check("R1", "gate after reset", int'(gate_en), 0);
        check("R1", "status after reset", int'(gate_status), 0);
    endtask

    task automatic t_sw_control();
        idle_off();
        hw_req = 1'b1;
        tick(2);
        check("R2", "hw_req ignored in sw mode", int'(gate_en), 0);
        sw_enable = 1'b1;
        tick(1);
        check("R2", "sw enable opens", int'(gate_en), 1);
        check("R4", "status lags open", int'(gate_status), 0);
        tick(SETTLE - 1);
        check("R4", "status before settle", int'(gate_status), 0);
        tick(1);
        check("R4", "status after settle", int'(gate_status), 1);
        sw_enable = 1'b0;
        tick(1);
        check("R6", "no hyst closes in one cycle", int'(gate_en), 0);
        check("R4", "status lags close", int'(gate_status), 1);
        tick(SETTLE);
        check("R4", "status follows close", int'(gate_status), 0);
        hw_req = 1'b0;
    endtask

    task automatic t_hw_control();
        idle_off();
        sw_select = 1'b0; sw_enable = 1'b1;
        tick(3);
        check("R3", "sw_enable ignored in hw mode", int'(gate_en), 0);
        hw_req = 1'b1;
        tick(1);
        check("R3", "hw_req opens", int'(gate_en), 1);
        hw_req = 1'b0;
        tick(1);
        check("R3", "hw_req drop closes", int'(gate_en), 0);
        sw_enable = 1'b0;
    endtask

    task automatic t_keep_on();
        idle_off();
        keep_on = 1'b1;
        tick(1);
        check("R5", "keep_on opens", int'(gate_en), 1);
        tick(LONG_OFF);
        check("R5", "keep_on holds with enable low", int'(gate_en), 1);
        keep_on = 1'b0;
        tick(1);
        check("R5", "release closes", int'(gate_en), 0);
    endtask

    task automatic t_hyst(input bit lng, input string req, input int exp_n);
        int n;
        idle_off();
        hyst_en = 1'b1; hyst_long = lng;
        sw_enable = 1'b1;
        tick(1);
        check("R10", "open with hysteresis set", int'(gate_en), 1);
        tick(SETTLE + 1);
        sw_enable = 1'b0;
        count_to_off(n);
        check(req, "turn-off edge count", n, exp_n);
        check("R4", "status still high at close", int'(gate_status), 1);
    endtask

    task automatic t_cancel();
        int drops = 0;
        idle_off();
        hyst_en = 1'b1; hyst_long = 1'b0;
        sw_enable = 1'b1;
        tick(SETTLE + 2);
        sw_enable = 1'b0;
        tick(2);
        sw_enable = 1'b1;
        for (int i = 0; i < LONG_OFF + 5; i++) begin
            tick(1);
            if (!gate_en) drops++;
        end
        check("R9", "cycles with gate low after cancel", drops, 0);
        sw_enable = 1'b0;
        count_to_off(drops);
        check("R9", "later turn-off still delayed", drops, SHORT_OFF + 1);
    endtask

    initial begin
        tick(3);
        t_reset();
        t_sw_control();
        t_hw_control();
        t_keep_on();
        t_hyst(1'b0, "R7", SHORT_OFF + 1);
        t_hyst(1'b1, "R8", LONG_OFF + 1);
        t_cancel();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule